// File: doc/BRIEF.md
# Endian-Aware Packed Decimal Converter

This block converts decimal numbers between the packed form (two BCD digits per byte) and the one-digit-per-byte character form. One `start` pulse picks the direction (pack or unpack), a digit count and two mode bits. The first mode bit says whether multi-byte data is stored little-endian. The second says whether the number's least significant digit comes first in printed text. Together these two bits decide which packed byte the effective address names and the order in which each operand is walked.

The block does not hold any data. It drives a source read offset and a destination write offset. Both are signed byte offsets from the effective address of the operand they belong to. The caller adds its own base addresses. Digits are handled from the most significant to the least significant, and one character byte is consumed or produced on each clock. Any non-decimal nibble or character raises a sticky error. That error is reported together with a one-cycle `done` pulse.

Top module: `pdec_conv`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `dst_we` are all 0.
- R2: The upper nibble of a packed byte holds the more significant digit. Unpack writes each digit as a character byte with upper nibble 0x3 and the digit value in the lower nibble.
- R3: Big-endian with most-significant-first text (`le_mode`=0, `lsd_first`=0): packed byte j (j=0 holds the most significant pair) is at offset +j, and digit k (k=0 most significant) of the character string is at offset +k.
- R4: Little-endian with most-significant-first text: packed byte j is at offset -j, so the effective address is the highest byte. Digit k is at character offset +k, so the element order is reversed between the two operands.
- R5: Little-endian with least-significant-first text: packed byte j is at offset B-1-j, where B is half the digit count. Digit k is at character offset N-1-k, where N is the digit count.
- R6: Big-endian with least-significant-first text: packed byte j is at offset -(B-1-j), so the effective address is the highest byte. Digit k is at character offset N-1-k.
- R7: Pack builds each packed byte from the lower nibbles of two consecutive characters. The more significant character goes into the upper nibble.
- R8: A packed nibble above 9, or a character outside 0x30..0x39, sets `err`. The conversion still runs to completion and writes every destination byte.
- R9: A digit count that is zero, odd, or greater than MAX_DIGITS gives `done` with `err`=1 on the next clock. No write is made.
- R10: A valid request is busy for N cycles. `done` is a one-cycle pulse in the cycle after the last step. A `start` that arrives while the block is busy is ignored.
- R11: Unpack writes on every busy cycle. Pack writes only on every second busy cycle, once both digits of a byte are known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| op_unpack | input | 1 | 1 = packed to characters, 0 = characters to packed |
| le_mode | input | 1 | 1 = little-endian data |
| lsd_first | input | 1 | 1 = text starts with the least significant digit |
| num_digits | input | LW | Digit count N |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error of the last request, held until the next accepted start |
| src_rd | output | 1 | Source read strobe |
| src_off | output | OW | Signed source offset from the source effective address |
| src_data | input | 8 | Source byte at `src_off`, same cycle |
| dst_we | output | 1 | Destination write strobe |
| dst_off | output | OW | Signed destination offset from the destination effective address |
| dst_data | output | 8 | Byte to write |

## Verification
Two cases can fall on the same clock. In the first, a new `start` arrives during the final busy step, while the last byte is being written and `done` is being produced. The bench raises `start`, with a different length, exactly in that last step. It expects the cycle count, the written bytes and the later idle state to match a run without that pulse. In the second, an error is detected on the final digit, so it must be folded into `err` on the same edge that raises `done`. The bench puts the bad digit last and checks `err` in the `done` cycle.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef struct packed {
    logic unpack;
    logic le;
    logic lsd;
  } pdc_mode_t;
endpackage

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int MAX_DIGITS = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len_in,
  input  pdc_mode_t     mode_in,
  output logic          busy,
  output logic [LW-1:0] step,
  output logic [LW-1:0] len_q,
  output pdc_mode_t     mode_q,
  output logic          done,
  output logic          accept,
  output logic          len_bad
);
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [LW-1:0] step_q, step_d;
  logic [LW-1:0] len_d;
  pdc_mode_t     mode_d;
  logic          len_ok, last;

  assign len_ok  = (len_in != '0) && !len_in[0] && (len_in <= LW'(MAX_DIGITS));
  assign accept  = start && !busy_q;
  assign len_bad = accept && !len_ok;
  assign last    = (step_q == len_q - LW'(1));

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    step_d = step_q;
    len_d  = len_q;
    mode_d = mode_q;
    if (busy_q) begin
      step_d = step_q + LW'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start) begin
      if (len_ok) begin
        busy_d = 1'b1;
        step_d = '0;
        len_d  = len_in;
        mode_d = mode_in;
      end else begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      len_q  <= '0;
      mode_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      step_q <= step_d;
      len_q  <= len_d;
      mode_q <= mode_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign step = step_q;
endmodule

// File: rtl/pdc_addr_gen.sv
module pdc_addr_gen
  import pdc_pkg::*;
#(
  parameter int LW = 6,
  localparam int OW = LW + 1
) (
  input  pdc_mode_t            mode,
  input  logic [LW-1:0]        len,
  input  logic [LW-1:0]        step,
  output logic signed [OW-1:0] pk_off,
  output logic signed [OW-1:0] ch_off,
  output logic                 hi_half
);
  logic signed [OW-1:0] j_s, k_s, n_s, b_s, rev_j;

  assign k_s     = $signed({1'b0, step});
  assign n_s     = $signed({1'b0, len});
  assign j_s     = k_s >>> 1;
  assign b_s     = n_s >>> 1;
  assign rev_j   = b_s - OW'(1) - j_s;
  assign hi_half = !step[0];

  always_comb begin
    unique case ({mode.le, mode.lsd})
      2'b00:   pk_off = j_s;
      2'b10:   pk_off = -j_s;
      2'b11:   pk_off = rev_j;
      default: pk_off = -rev_j;
    endcase
    ch_off = mode.lsd ? (n_s - OW'(1) - k_s) : k_s;
  end
endmodule

// File: rtl/pdc_datapath.sv
module pdc_datapath (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       unpack,
  input  logic       hi_half,
  input  logic       accept,
  input  logic       len_bad,
  input  logic [7:0] src_data,
  output logic [7:0] dst_data,
  output logic       wr,
  output logic       err
);
  logic [3:0] hold_q, hold_d;
  logic       err_q, err_d;
  logic [3:0] nib;
  logic       step_bad;
  logic       hold_en;

  assign nib     = hi_half ? src_data[7:4] : src_data[3:0];
  assign hold_en = busy && !unpack && hi_half;

  always_comb begin
    if (unpack) begin
      dst_data = {4'h3, nib};
      wr       = busy;
      step_bad = (nib > 4'd9);
    end else begin
      dst_data = {hold_q, src_data[3:0]};
      wr       = busy && !hi_half;
      step_bad = (src_data[7:4] != 4'h3) || (src_data[3:0] > 4'd9);
    end
  end

  always_comb begin
    hold_d = hold_en ? src_data[3:0] : hold_q;
    if (accept)                 err_d = len_bad;
    else if (busy && step_bad)  err_d = 1'b1;
    else                        err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 4'h0;
      err_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      err_q  <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/pdec_conv.sv
module pdec_conv
  import pdc_pkg::*;
#(
  parameter int MAX_DIGITS = 32,
  localparam int LW = $clog2(MAX_DIGITS + 1),
  localparam int OW = LW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 op_unpack,
  input  logic                 le_mode,
  input  logic                 lsd_first,
  input  logic [LW-1:0]        num_digits,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 src_rd,
  output logic signed [OW-1:0] src_off,
  input  logic [7:0]           src_data,
  output logic                 dst_we,
  output logic signed [OW-1:0] dst_off,
  output logic [7:0]           dst_data
);
  pdc_mode_t            mode_in, mode_q;
  logic [LW-1:0]        step, len_q;
  logic                 accept, len_bad, hi_half;
  logic signed [OW-1:0] pk_off, ch_off;
  logic                 run_unpack;

  assign mode_in    = '{unpack: op_unpack, le: le_mode, lsd: lsd_first};
  assign run_unpack = mode_q.unpack;

  pdc_ctrl #(.MAX_DIGITS(MAX_DIGITS), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(num_digits),
    .mode_in(mode_in), .busy(busy), .step(step), .len_q(len_q),
    .mode_q(mode_q), .done(done), .accept(accept), .len_bad(len_bad)
  );

  pdc_addr_gen #(.LW(LW)) u_addr (
    .mode(mode_q), .len(len_q), .step(step),
    .pk_off(pk_off), .ch_off(ch_off), .hi_half(hi_half)
  );

  pdc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .busy(busy), .unpack(run_unpack),
    .hi_half(hi_half), .accept(accept), .len_bad(len_bad),
    .src_data(src_data), .dst_data(dst_data), .wr(dst_we), .err(err)
  );

  assign src_rd  = busy;
  assign src_off = run_unpack ? pk_off : ch_off;
  assign dst_off = run_unpack ? ch_off : pk_off;
endmodule

// File: rtl/pdec_conv_chk.sv
module pdec_conv_chk #(
  parameter int MAX_DIGITS = 32,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] num_digits,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          dst_we,
  input logic [7:0]    dst_data,
  input logic          run_unpack
);
  logic req_bad;
  assign req_bad = (num_digits == '0) || num_digits[0] || (num_digits > LW'(MAX_DIGITS));

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> busy); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_BAD_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && req_bad) |=> (done && err && !busy)); // R9
  AST_CHAR_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && run_unpack) |-> (dst_data[7:4] == 4'h3)); // R2
  AST_UNPACK_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_unpack) |-> dst_we); // R11
  AST_PACK_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && !run_unpack) |=> !dst_we); // R11
endmodule

bind pdec_conv pdec_conv_chk #(.MAX_DIGITS(MAX_DIGITS), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .num_digits(num_digits),
  .busy(busy), .done(done), .err(err), .dst_we(dst_we),
  .dst_data(dst_data), .run_unpack(run_unpack)
);

// File: tb/pdec_conv_bench.sv
module pdec_conv_bench;
  localparam int MAXD = 32;
  localparam int LW = $clog2(MAXD + 1);
  localparam int OW = LW + 1;

  logic clk, rst_n, start, op_unpack, le_mode, lsd_first;
  logic [LW-1:0] num_digits;
  logic busy, done, err, src_rd, dst_we;
  logic signed [OW-1:0] src_off, dst_off;
  logic [7:0] src_data, dst_data;

  logic [7:0] src_mem [0:127];
  logic [7:0] dst_mem [0:127];
  logic [7:0] exp_mem [0:127];
  int n_chk, n_bad;

  pdec_conv #(.MAX_DIGITS(MAXD)) u_pdec_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .op_unpack(op_unpack),
    .le_mode(le_mode), .lsd_first(lsd_first), .num_digits(num_digits),
    .busy(busy), .done(done), .err(err), .src_rd(src_rd), .src_off(src_off),
    .src_data(src_data), .dst_we(dst_we), .dst_off(dst_off), .dst_data(dst_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign src_data = src_mem[int'(src_off) + 64];
  always @(posedge clk) if (dst_we) dst_mem[int'(dst_off) + 64] <= dst_data;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pk_pos(bit le, bit lsd, int j, int b);
    case ({le, lsd})
      2'b00: return j;
      2'b10: return -j;
      2'b11: return b - 1 - j;
      default: return -(b - 1 - j);
    endcase
  endfunction

  function automatic int ch_pos(bit lsd, int k, int n);
    return lsd ? n - 1 - k : k;
  endfunction

  // one conversion; bad_k marks a corrupted digit, inj_at the cycle of a stray start
  task automatic run(input string req, input bit unp, input bit le, input bit lsd,
                     input int n, input int seed, input int bad_k, input int inj_at);
    int dig[MAXD];
    logic [7:0] chv[MAXD];
    int cycles, miss, first;
    bit ok_len;
    ok_len = (n > 0) && (n % 2 == 0) && (n <= MAXD);
    for (int i = 0; i < 128; i++) begin
      src_mem[i] = 8'h00; dst_mem[i] = 8'hEE; exp_mem[i] = 8'hEE;
    end
    if (ok_len) begin
      for (int k = 0; k < n; k++) begin
        dig[k] = (k * 7 + seed) % 10;
        chv[k] = {4'h3, 4'(dig[k])};
        if (k == bad_k) begin
          dig[k] = 12;
          chv[k] = 8'h41;
        end
      end
      for (int k = 0; k < n; k++) begin
        if (unp) begin
          exp_mem[ch_pos(lsd, k, n) + 64] = {4'h3, 4'(dig[k])};
          if (k % 2 == 0)
            src_mem[pk_pos(le, lsd, k / 2, n / 2) + 64] = {4'(dig[k]), 4'(dig[k + 1])};
        end else begin
          src_mem[ch_pos(lsd, k, n) + 64] = chv[k];
          if (k % 2 == 0)
            exp_mem[pk_pos(le, lsd, k / 2, n / 2) + 64] = {chv[k][3:0], chv[k + 1][3:0]};
        end
      end
    end
    @(negedge clk);
    op_unpack = unp; le_mode = le; lsd_first = lsd; num_digits = LW'(n); start = 1'b1;
    cycles = 0;
    while (cycles < 200) begin
      @(negedge clk);
      cycles++;
      if (cycles == 1 || cycles == inj_at + 1) start = 1'b0;
      if (cycles == inj_at) begin
        start = 1'b1; num_digits = LW'(4);
      end
      if (done) break;
    end
    start = 1'b0;
    chk(cycles == (ok_len ? n + 1 : 1), req, "cycles to done", cycles, ok_len ? n + 1 : 1);
    chk(err == (!ok_len || bad_k >= 0), req, "err at done", err, (!ok_len || bad_k >= 0));
    repeat (3) @(negedge clk);
    chk(!busy && !done, req, "idle after done", {busy, done}, 0);
    miss = 0; first = -1;
    for (int i = 0; i < 128; i++)
      if (dst_mem[i] !== exp_mem[i]) begin
        miss++;
        if (first < 0) first = i;
      end
    if (first < 0) first = 0;
    chk(miss == 0, req, $sformatf("dst byte at offset %0d", first - 64),
        dst_mem[first], exp_mem[first]);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    start = 1'b0; op_unpack = 1'b0; le_mode = 1'b0; lsd_first = 1'b0; num_digits = '0;
    for (int i = 0; i < 128; i++) begin
      src_mem[i] = 8'h00; dst_mem[i] = 8'hEE;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !dst_we, "R1", "reset outputs",
        {busy, done, err, dst_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after release", {busy, done}, 0);

    run("R3 R2 R11 unpack", 1, 0, 0, 6, 1, -1, 0);
    run("R4 unpack", 1, 1, 0, 6, 2, -1, 0);
    run("R5 unpack", 1, 1, 1, 6, 3, -1, 0);
    run("R6 unpack", 1, 0, 1, 6, 4, -1, 0);
    run("R6 unpack two digits", 1, 0, 1, 2, 5, -1, 0);
    run("R7 R3 pack", 0, 0, 0, 8, 6, -1, 0);
    run("R7 R4 pack", 0, 1, 0, 8, 7, -1, 0);
    run("R7 R5 pack", 0, 1, 1, 8, 8, -1, 0);
    run("R7 R6 R11 pack", 0, 0, 1, 8, 9, -1, 0);
    run("R10 R4 full length", 1, 1, 0, MAXD, 0, -1, 0);
    run("R8 unpack bad nibble", 1, 0, 0, 6, 1, 3, 0);
    run("R8 pack bad char last", 0, 1, 1, 6, 2, 5, 0);
    run("R9 odd length", 1, 0, 0, 5, 0, -1, 0);
    run("R9 zero length", 0, 0, 0, 0, 0, -1, 0);
    run("R9 too long", 1, 1, 0, MAXD + 2, 0, -1, 0);
    run("R10 start mid-run", 1, 0, 1, 10, 3, -1, 4);
    run("R10 start in last step", 0, 1, 0, 6, 4, -1, 6);
    run("R8 error clears on next start", 1, 0, 0, 4, 7, -1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule